// File: doc/BRIEF.md
# Segmented Address Translation Controller

This block sits between a processor and a memory interface and widens a 16-bit processor address into a 24-bit real address. It supplies the upper byte of the real address from one of two segment registers. Loads use the read segment and stores use the write segment. The lower 16 bits pass to memory unchanged on the processor's own address bus.

The two highest addresses do not reach memory. Instead they reach the segment registers directly over the low byte of the data bus:

- 0xFFFF selects the read segment.
- 0xFFFE selects the write segment.

Every request drives the upper address byte at once, in parallel with the address decode. No memory request is issued for a reserved address, so a stale upper byte does no harm.

The processor side has two passive four-phase channels, one for loads and one for stores. The memory side has two active four-phase channels. These use a lazy return-to-zero: a new memory request waits until the acknowledge of the previous one has fallen. The block is a clocked, synthesizable model of a self-timed controller.

Top module: `seg_xlate_ctrl`

## Requirements
- R1: After reset, both segment registers read back as zero, and every acknowledge and memory request output is low.
- R2: A load from 0xFFFF returns the read segment on `cpu_rdata` while `ld_ack` is high, and raises no memory request.
- R3: A load from 0xFFFE returns the write segment on `cpu_rdata` while `ld_ack` is high, and raises no memory request.
- R4: A store to 0xFFFF loads `cpu_wdata` into the read segment. A store to 0xFFFE loads it into the write segment. Neither store raises a memory request.
- R5: A load from any other address raises `mem_ld_req` while `hi_addr` holds the read segment. `ld_ack` rises only after `mem_ld_ack` has been seen high.
- R6: A store to any other address raises `mem_st_req` while `hi_addr` holds the write segment. `st_ack` rises only after `mem_st_ack` has been seen high.
- R7: Every request, reserved or not, updates `hi_addr`: loads set it to the read segment and stores to the write segment. The value holds until the next request.
- R8: A processor acknowledge stays high while its request is high. It falls after the request falls, and the memory request falls with it.
- R9: A memory request is never raised while the acknowledge of the same memory channel is still high.
- R10: If load and store requests are high together, the load is served completely before the store.
- R11: The two memory requests are never high together, and a memory request is never high for a reserved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Processor load request |
| ld_ack | output | 1 | Processor load acknowledge |
| st_req | input | 1 | Processor store request |
| st_ack | output | 1 | Processor store acknowledge |
| cpu_addr | input | 16 | Processor address, held stable for the whole handshake |
| cpu_wdata | input | 8 | Store data for segment writes |
| cpu_rdata | output | 8 | Segment value returned on reserved loads, zero otherwise |
| hi_addr | output | 8 | Upper byte of the real address |
| mem_ld_req | output | 1 | Memory load request |
| mem_ld_ack | input | 1 | Memory load acknowledge |
| mem_st_req | output | 1 | Memory store request |
| mem_st_ack | input | 1 | Memory store acknowledge |

## Verification
The bench targets the decode boundary at 0xFFFD, 0x7FFF and 0xFFFE/0xFFFF. A comparator that ignores the top bit or mishandles bit 0 would send a segment access to memory, or hand a memory access to the wrong register. The bench varies the memory acknowledge's fall delay so that back-to-back memory accesses test the lazy return-to-zero. A design that skips that wait raises a request over a live acknowledge. The bench raises both processor requests together to expose a priority error, which would show up as a store acknowledge or a memory store during the load. The upper byte is checked after reserved accesses as well, which catches a design that updates it only for memory traffic.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_MEM  = 2'd0,
    ACC_RSEG = 2'd1,
    ACC_WSEG = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_MEM    = 2'd2,
    ST_HOLD   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/sx_addr_decode.sv
module sx_addr_decode
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind
);
  logic top_all_ones;

  // one wide AND over the upper bits; bit 0 picks the register
  assign top_all_ones = &addr[ADDR_W-1:1];

  always_comb begin
    if (!top_all_ones)  kind = ACC_MEM;
    else if (addr[0])   kind = ACC_RSEG;
    else                kind = ACC_WSEG;
  end
endmodule

// File: rtl/sx_seg_bank.sv
module sx_seg_bank #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rseg_we,
  input  logic             wseg_we,
  input  logic [SEG_W-1:0] wr_value,
  output logic [SEG_W-1:0] rseg,
  output logic [SEG_W-1:0] wseg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rseg <= '0;
    else if (rseg_we) rseg <= wr_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wseg <= '0;
    else if (wseg_we) wseg <= wr_value;
  end
endmodule

// File: rtl/sx_ctrl.sv
module sx_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic             st_req,
  input  logic             mem_ld_ack,
  input  logic             mem_st_ack,
  input  acc_kind_e        kind,
  input  logic [SEG_W-1:0] rseg,
  input  logic [SEG_W-1:0] wseg,
  output logic             rseg_we,
  output logic             wseg_we,
  output logic             ld_ack,
  output logic             st_ack,
  output logic             mem_ld_req,
  output logic             mem_st_req,
  output logic [SEG_W-1:0] hi_addr,
  output logic [SEG_W-1:0] rdata
);
  ctl_state_e       state_q, state_n;
  logic             is_st_q, is_st_n;
  logic             ld_ack_n, st_ack_n, mld_n, mst_n;
  logic [SEG_W-1:0] hi_n, rdata_n;
  logic             own_req, own_mack;

  assign own_req  = is_st_q ? st_req : ld_req;
  assign own_mack = is_st_q ? mem_st_ack : mem_ld_ack;

  always_comb begin
    state_n  = state_q;
    is_st_n  = is_st_q;
    ld_ack_n = ld_ack;
    st_ack_n = st_ack;
    mld_n    = mem_ld_req;
    mst_n    = mem_st_req;
    hi_n     = hi_addr;
    rdata_n  = rdata;
    rseg_we  = 1'b0;
    wseg_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // load wins when both requests are present
        if (ld_req) begin
          is_st_n = 1'b0;
          hi_n    = rseg;
          state_n = ST_DECODE;
        end else if (st_req) begin
          is_st_n = 1'b1;
          hi_n    = wseg;
          state_n = ST_DECODE;
        end
      end
      ST_DECODE: begin
        unique case (kind)
          ACC_MEM: begin
            // lazy active: previous acknowledge must be back to zero
            if (!own_mack) begin
              mld_n   = !is_st_q;
              mst_n   = is_st_q;
              state_n = ST_MEM;
            end
          end
          ACC_RSEG, ACC_WSEG: begin
            if (is_st_q) begin
              rseg_we  = (kind == ACC_RSEG);
              wseg_we  = (kind == ACC_WSEG);
              st_ack_n = 1'b1;
            end else begin
              rdata_n  = (kind == ACC_RSEG) ? rseg : wseg;
              ld_ack_n = 1'b1;
            end
            state_n = ST_HOLD;
          end
          default: state_n = ST_IDLE;
        endcase
      end
      ST_MEM: begin
        if (own_mack) begin
          ld_ack_n = !is_st_q;
          st_ack_n = is_st_q;
          state_n  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!own_req) begin
          ld_ack_n = 1'b0;
          st_ack_n = 1'b0;
          mld_n    = 1'b0;
          mst_n    = 1'b0;
          rdata_n  = '0;
          state_n  = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      is_st_q    <= 1'b0;
      ld_ack     <= 1'b0;
      st_ack     <= 1'b0;
      mem_ld_req <= 1'b0;
      mem_st_req <= 1'b0;
      hi_addr    <= '0;
      rdata      <= '0;
    end else begin
      state_q    <= state_n;
      is_st_q    <= is_st_n;
      ld_ack     <= ld_ack_n;
      st_ack     <= st_ack_n;
      mem_ld_req <= mld_n;
      mem_st_req <= mst_n;
      hi_addr    <= hi_n;
      rdata      <= rdata_n;
    end
  end
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  output logic              ld_ack,
  input  logic              st_req,
  output logic              st_ack,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [SEG_W-1:0]  hi_addr,
  output logic              mem_ld_req,
  input  logic              mem_ld_ack,
  output logic              mem_st_req,
  input  logic              mem_st_ack
);
  localparam int PAD_W = (DATA_W > SEG_W) ? DATA_W - SEG_W : 0;

  acc_kind_e        kind;
  logic             rseg_we, wseg_we;
  logic [SEG_W-1:0] rseg, wseg, seg_rdata;

  sx_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (cpu_addr),
    .kind (kind)
  );

  sx_seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rseg_we  (rseg_we),
    .wseg_we  (wseg_we),
    .wr_value (cpu_wdata[SEG_W-1:0]),
    .rseg     (rseg),
    .wseg     (wseg)
  );

  sx_ctrl #(.SEG_W(SEG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_req     (ld_req),
    .st_req     (st_req),
    .mem_ld_ack (mem_ld_ack),
    .mem_st_ack (mem_st_ack),
    .kind       (kind),
    .rseg       (rseg),
    .wseg       (wseg),
    .rseg_we    (rseg_we),
    .wseg_we    (wseg_we),
    .ld_ack     (ld_ack),
    .st_ack     (st_ack),
    .mem_ld_req (mem_ld_req),
    .mem_st_req (mem_st_req),
    .hi_addr    (hi_addr),
    .rdata      (seg_rdata)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cpu_rdata = {{PAD_W{1'b0}}, seg_rdata};
    end else begin : g_nopad
      assign cpu_rdata = seg_rdata[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_req,
  input logic              ld_ack,
  input logic              st_req,
  input logic              st_ack,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_ld_req,
  input logic              mem_ld_ack,
  input logic              mem_st_req,
  input logic              mem_st_ack
);
  // R9
  lazy_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ld_req) |-> !$past(mem_ld_ack));
  // R9
  lazy_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_st_req) |-> !$past(mem_st_ack));
  // R8
  ld_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ack && ld_req) |=> ld_ack);
  // R8
  st_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ack && st_req) |=> st_ack);
  // R5
  ld_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ld_ack) && mem_ld_req) |-> $past(mem_ld_ack));
  // R6
  st_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_ack) && mem_st_req) |-> $past(mem_st_ack));
  // R11
  one_mem_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ld_req && mem_st_req));
  // R11
  no_mem_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ld_req || mem_st_req) |-> !(&cpu_addr[ADDR_W-1:1]));
  // R10
  one_cpu_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ack && st_ack));
endmodule

bind seg_xlate_ctrl seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/seg_xlate_ctrl_bench.sv
module seg_xlate_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0, st_req = 1'b0;
  logic        ld_ack, st_ack;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, hi_addr;
  logic        mem_ld_req, mem_st_req;
  logic        mem_ld_ack = 1'b0, mem_st_ack = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] exp_r = '0, exp_w = '0;
  bit   mem_ld_seen, mem_st_seen;
  logic [7:0] seen_hi;
  bit   done = 0;

  always #2 clk = ~clk;

  seg_xlate_ctrl u_seg_xlate_ctrl (.*);

  function automatic bit is_reserved(input logic [15:0] a);
    return (a[15:1] == 15'h7FFF);
  endfunction

  function automatic logic [7:0] exp_load(input logic [15:0] a);
    if (!is_reserved(a)) return 8'h00;
    return a[0] ? exp_r : exp_w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: random delays, lazy release of acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ld_req && !mem_ld_ack) begin
        mem_ld_seen = 1; seen_hi = hi_addr;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        mem_ld_ack = 1'b1;
        while (mem_ld_req) @(negedge clk);
        repeat ($urandom_range(0, 4)) @(negedge clk);
        mem_ld_ack = 1'b0;
      end else if (mem_st_req && !mem_st_ack) begin
        mem_st_seen = 1; seen_hi = hi_addr;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        mem_st_ack = 1'b1;
        while (mem_st_req) @(negedge clk);
        repeat ($urandom_range(0, 4)) @(negedge clk);
        mem_st_ack = 1'b0;
      end
    end
  end

  // R9 monitor at the ports
  logic p_mlr = 0, p_mla = 0, p_msr = 0, p_msa = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_ld_req && !p_mlr) chk(!p_mla, "R9 ld", p_mla, 0);
      if (mem_st_req && !p_msr) chk(!p_msa, "R9 st", p_msa, 0);
      // R11
      if (mem_ld_req && mem_st_req) chk(0, "R11 both", 1, 0);
    end
    p_mlr = mem_ld_req; p_mla = mem_ld_ack; p_msr = mem_st_req; p_msa = mem_st_ack;
  end

  task automatic wait_sig(ref logic s, input logic v, input string req);
    int n = 0;
    while (s !== v && n < 200) begin @(negedge clk); n++; end
    if (s !== v) chk(0, {req, " timeout"}, s, v);
  endtask

  task automatic do_load(input logic [15:0] a);
    logic [7:0] exp_hi;
    exp_hi = exp_r;
    mem_ld_seen = 0; mem_st_seen = 0;
    @(negedge clk); cpu_addr = a; ld_req = 1'b1;
    wait_sig(ld_ack, 1'b1, "R8 ld_ack rise");
    if (is_reserved(a)) begin
      chk(cpu_rdata == exp_load(a), a[0] ? "R2 rdata" : "R3 rdata", cpu_rdata, exp_load(a));
      chk(!mem_ld_seen && !mem_ld_req, "R11 reserved load", mem_ld_seen, 0);
      chk(hi_addr == exp_hi, "R7 hi after reserved load", hi_addr, exp_hi);
    end else begin
      chk(mem_ld_seen && mem_ld_req && mem_ld_ack, "R5 mem load", mem_ld_seen, 1);
      chk(seen_hi == exp_hi, "R5 hi_addr", seen_hi, exp_hi);
    end
    @(negedge clk);
    chk(ld_ack, "R8 ack held", ld_ack, 1);
    ld_req = 1'b0;
    wait_sig(ld_ack, 1'b0, "R8 ld_ack fall");
    chk(!mem_ld_req, "R8 mem req dropped", mem_ld_req, 0);
  endtask

  task automatic do_store(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] exp_hi;
    exp_hi = exp_w;
    mem_ld_seen = 0; mem_st_seen = 0;
    @(negedge clk); cpu_addr = a; cpu_wdata = d; st_req = 1'b1;
    wait_sig(st_ack, 1'b1, "R8 st_ack rise");
    if (is_reserved(a)) begin
      chk(!mem_st_seen && !mem_st_req, "R4 no mem store", mem_st_seen, 0);
      chk(hi_addr == exp_hi, "R7 hi after reserved store", hi_addr, exp_hi);
      if (a[0]) exp_r = d; else exp_w = d;
    end else begin
      chk(mem_st_seen && mem_st_req && mem_st_ack, "R6 mem store", mem_st_seen, 1);
      chk(seen_hi == exp_hi, "R6 hi_addr", seen_hi, exp_hi);
    end
    @(negedge clk); st_req = 1'b0;
    wait_sig(st_ack, 1'b0, "R8 st_ack fall");
    chk(!mem_st_req, "R8 mem st req dropped", mem_st_req, 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  r;
    void'($urandom(32'h5e61));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ld_ack && !st_ack && !mem_ld_req && !mem_st_req, "R1 outputs",
        {ld_ack, st_ack, mem_ld_req, mem_st_req}, 0);
    chk(hi_addr == 0 && cpu_rdata == 0, "R1 data", hi_addr, 0);
    rst_n = 1'b1;
    do_load(16'hFFFF);  // R1 read segment zero
    do_load(16'hFFFE);  // R1 write segment zero
    do_store(16'hFFFF, 8'hA5);   // R4
    do_store(16'hFFFE, 8'h3C);   // R4
    do_load(16'hFFFF);           // R2
    do_load(16'hFFFE);           // R3
    do_load(16'hFFFD);           // R5 boundary
    do_load(16'h7FFF);           // R5 top bit clear
    do_store(16'hFFFD, 8'h11);   // R6
    do_load(16'h1234); do_load(16'h4321);  // R9 back to back
    do_store(16'h0000, 8'h22); do_store(16'h0001, 8'h33);
    // R10 simultaneous requests: load on 0xFFFE served first
    @(negedge clk); cpu_addr = 16'hFFFE; cpu_wdata = 8'hC7; ld_req = 1; st_req = 1;
    wait_sig(ld_ack, 1'b1, "R10 load first");
    chk(!st_ack && cpu_rdata == exp_w, "R10 load served first", cpu_rdata, exp_w);
    @(negedge clk); ld_req = 0;
    wait_sig(st_ack, 1'b1, "R10 store after");
    exp_w = 8'hC7;
    @(negedge clk); st_req = 0;
    wait_sig(st_ack, 1'b0, "R10 st_ack fall");
    do_load(16'hFFFE);           // R10 store took effect
    // random mix
    for (int i = 0; i < 400; i++) begin
      r = 8'($urandom);
      case ($urandom_range(0, 3))
        0: a = 16'hFFFE | 16'($urandom_range(0, 1));
        1: a = 16'hFFFD;
        default: a = 16'($urandom);
      endcase
      if ($urandom_range(0, 1)) do_load(a); else do_store(a, r);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule